// File: doc/BRIEF.md
# Bit-Addressable System Control Latch with Deferred Memory Bank Switch

This block is the system control output port of an 8-bit host with a Z80-style bus. The port does not take a whole byte. Each write changes exactly one of eight single-bit controls. Data bits [2:0] pick which control changes, and data bit 4 is the value it takes. The controls are:

- the ROM overlay / RAM inhibit,
- display blanking,
- the 525/625 line standard,
- RGB or component video,
- cassette motor,
- beeper,
- printer strobe,
- cassette write data.

The bank control is not applied on the write cycle. A write to control 0 only stores a pending bank state, which is the inverse of the written bit. The bank-select output takes that pending state at the first clock on which the host's opcode-fetch strobe `m1_n` is low after the write. This lets the instruction that follows the port write still be fetched from the old memory. The same two I/O addresses also return two read-only status bytes. These are built from the cassette, printer, model-ID, boot-mode, reset-switch and colour-board inputs.

Reset is asynchronous and active low, and its release passes through a two-stage synchronizer. Register updates therefore begin on the third rising clock edge after `rst_n` goes high.

Top module: `sysctl_bitlatch`

## Requirements
- R1: A write (`io_wr`=1 with a decoded address, sampled on the rising clock) changes only the control selected by `io_wdata[2:0]`, loading it with `io_wdata[4]`. `io_wdata[3]` and bits [7:5] have no effect, and all other controls keep their value.
- R2: The control indices map to the outputs as follows: 1 to `disp_off`, 2 to `line625`, 3 to `comp_video`, 4 to `cas_motor`, 5 to `beep_on`, 6 to `prn_strobe` and 7 to `cas_wdata`. Index 0 is the bank control.
- R3: A write to index 0 sets the pending bank state to the inverse of `io_wdata[4]`. `rom_overlay` does not change on any edge where `m1_n` is high.
- R4: On every rising edge where `m1_n` is low, `rom_overlay` takes the pending bank state held before that edge. If a write to index 0 lands on the same edge, the bank output gets the earlier pending value and the new value waits for the next `m1_n`-low edge.
- R5: Writes are decoded when `io_addr[7:0]` is 0x1C or 0x1D, whatever `io_addr[15:8]` holds. A write at any other low byte changes nothing.
- R6: While `io_rd`=1 and `io_addr[7:0]`=0x1D, `io_rdata` has this layout:
  - bit 7 = `cas_rdata`
  - bit 6 = 1
  - bit 5 = 0
  - bit 4 = `prn_busy`
  - bit 3 = `prn_ack`
  - bit 2 = `model_id`
  - bits [1:0] = `boot_mode`
- R7: While `io_rd`=1 and `io_addr[7:0]`=0x1C, `io_rdata` has this layout:
  - bit 7 = `reset_sw`
  - bit 4 = `colour_board_n`
  - bit 2 = `model_id`
  - all other bits 0
- R8: Reset has the following effect:
  - `rom_overlay` = 1 and the pending bank state = 1;
  - the seven other controls = 0;
  - these values hold until the third rising edge after `rst_n` is released.
- R9: `io_rdata` is 0 when `io_rd` is 0, and when the low address byte is neither 0x1C nor 0x1D. Upper address bits are ignored for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address; only the low byte is decoded |
| io_wdata | input | 8 | Write data: [2:0] control index, [4] value |
| io_wr | input | 1 | I/O write strobe, sampled on the rising edge |
| io_rd | input | 1 | I/O read strobe (combinational read) |
| m1_n | input | 1 | Opcode-fetch strobe, active low, sampled on the rising edge |
| cas_rdata | input | 1 | Cassette read data |
| prn_busy | input | 1 | Printer busy |
| prn_ack | input | 1 | Printer acknowledge |
| model_id | input | 1 | Model identification bit |
| boot_mode | input | 2 | Boot mode straps |
| reset_sw | input | 1 | Power-on / reset switch state |
| colour_board_n | input | 1 | Colour board present, active low |
| io_rdata | output | 8 | Status read data |
| rom_overlay | output | 1 | Bank select, 1 = ROM overlaid on low memory |
| disp_off | output | 1 | Display blanking |
| line625 | output | 1 | 1 = 625-line standard, 0 = 525 |
| comp_video | output | 1 | 1 = component video, 0 = RGB |
| cas_motor | output | 1 | Cassette motor on |
| beep_on | output | 1 | Beeper on |
| prn_strobe | output | 1 | Printer strobe |
| cas_wdata | output | 1 | Cassette write data |

## Verification
A bank-control write and an opcode-fetch strobe can fall on the same clock edge. When they do, the bank output must take the previously pending state, and the newly written state must be applied only at the following fetch. A directed sequence provokes this case and checks the bank output at the two edges that follow. A long randomized run also produces the collision often, because it drives `io_wr` and `m1_n` independently. A behavioural reference model in the bench, updated on every rising edge, judges every output on every cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [2:0] {
    CTL_BANK      = 3'd0,
    CTL_DISP_OFF  = 3'd1,
    CTL_LINE625   = 3'd2,
    CTL_COMPVID   = 3'd3,
    CTL_CAS_MOTOR = 3'd4,
    CTL_BEEP      = 3'd5,
    CTL_PRN_STB   = 3'd6,
    CTL_CAS_WR    = 3'd7
  } ctl_idx_e;

  localparam logic [7:0] PORT_STAT_A = 8'h1C;
  localparam logic [7:0] PORT_STAT_B = 8'h1D;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_CTL = 8,
  parameter int unsigned VAL_BIT = 4,
  parameter logic [7:0]  PORT_A  = sysctl_pkg::PORT_STAT_A,
  parameter logic [7:0]  PORT_B  = sysctl_pkg::PORT_STAT_B,
  localparam int unsigned SEL_W  = $clog2(NUM_CTL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic [DATA_W-1:0]  io_wdata,
  input  logic               io_wr,
  input  logic               io_rd,
  output logic [NUM_CTL-1:0] ctl_wen,
  output logic               ctl_val,
  output logic               rd_a,
  output logic               rd_b
);
  logic [7:0]       low_byte;
  logic [SEL_W-1:0] sel;
  logic             hit_a;
  logic             hit_b;
  logic             wr_hit;
  logic             unused_bits;

  assign low_byte    = io_addr[7:0];
  assign sel         = io_wdata[SEL_W-1:0];
  assign unused_bits = ^{io_addr[ADDR_W-1:8], io_wdata[DATA_W-1:VAL_BIT+1], io_wdata[VAL_BIT-1:SEL_W]};

  always_comb begin
    hit_a  = (low_byte == PORT_A);
    hit_b  = (low_byte == PORT_B);
    wr_hit = io_wr && (hit_a || hit_b);
    rd_a   = io_rd && hit_a;
    rd_b   = io_rd && hit_b;
  end

  assign ctl_val = io_wdata[VAL_BIT];

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_wen
    assign ctl_wen[i] = wr_hit && (sel == SEL_W'(i));
  end

  // R1: one write touches at most one control
  p_single_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_wen));

  // R5: strobes only appear for a decoded low byte
  p_decode_ports_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wen != '0) |-> (io_addr[7:0] == PORT_A || io_addr[7:0] == PORT_B));

  // R9: the two read selects never overlap
  p_read_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_a && rd_b));
endmodule

// File: rtl/sysctl_ffbank.sv
module sysctl_ffbank #(
  parameter int unsigned NUM_CTL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTL-1:1] ctl_wen,
  input  logic               ctl_val,
  output logic [NUM_CTL-1:1] ctl_q
);
  for (genvar i = 1; i < NUM_CTL; i++) begin : g_ff
    logic q_r;
    logic q_nxt;

    always_comb begin
      q_nxt = q_r;
      if (ctl_wen[i]) q_nxt = ctl_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= 1'b0;
      else        q_r <= q_nxt;
    end

    assign ctl_q[i] = q_r;

    // R1: selected control takes the written value
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wen[i] |=> (ctl_q[i] == $past(ctl_val)));

    // R1: unselected control keeps its value
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wen[i] |=> $stable(ctl_q[i]));
  end
endmodule

// File: rtl/sysctl_bankdefer.sv
module sysctl_bankdefer (
  input  logic clk,
  input  logic rst_n,
  input  logic bank_wen,
  input  logic bank_val,
  input  logic m1_n,
  output logic bank_sel
);
  logic pend_r;
  logic pend_nxt;
  logic bank_r;
  logic bank_nxt;
  logic bank_en;

  assign bank_en = !m1_n;

  always_comb begin
    pend_nxt = pend_r;
    if (bank_wen) pend_nxt = !bank_val;
    bank_nxt = bank_r;
    if (bank_en) bank_nxt = pend_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_r <= 1'b1;
      bank_r <= 1'b1;
    end else begin
      pend_r <= pend_nxt;
      bank_r <= bank_nxt;
    end
  end

  assign bank_sel = bank_r;

  // R3: pending state stores the inverse of the written bit
  p_pend_inverse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wen |=> (pend_r == !$past(bank_val)));

  // R3: no bank change without an opcode fetch
  p_no_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m1_n |=> $stable(bank_sel));

  // R4: a fetch edge applies the value pending before it
  p_fetch_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_n |=> (bank_sel == $past(pend_r)));
endmodule

// File: rtl/sysctl_status.sv
module sysctl_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_a,
  input  logic       rd_b,
  input  logic       cas_rdata,
  input  logic       prn_busy,
  input  logic       prn_ack,
  input  logic       model_id,
  input  logic [1:0] boot_mode,
  input  logic       reset_sw,
  input  logic       colour_board_n,
  output logic [7:0] rdata
);
  logic [7:0] byte_a;
  logic [7:0] byte_b;

  always_comb begin
    byte_a = {reset_sw, 2'b00, colour_board_n, 1'b0, model_id, 2'b00};
    byte_b = {cas_rdata, 1'b1, 1'b0, prn_busy, prn_ack, model_id, boot_mode};
    rdata  = 8'h00;
    if (rd_a)      rdata = byte_a;
    else if (rd_b) rdata = byte_b;
  end

  // R6: the second status byte always carries a one in bit 6
  p_fixed_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b |-> rdata[6]);

  // R7: the first status byte never drives bit 6, 5, 3, 1 or 0
  p_zero_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a |-> ((rdata & 8'h6B) == 8'h00));

  // R9: no read select, no data
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_a || rd_b) |-> (rdata == 8'h00));
endmodule

// File: rtl/sysctl_bitlatch.sv
module sysctl_bitlatch #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_CTL = 8,
  parameter int unsigned VAL_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              m1_n,
  input  logic              cas_rdata,
  input  logic              prn_busy,
  input  logic              prn_ack,
  input  logic              model_id,
  input  logic [1:0]        boot_mode,
  input  logic              reset_sw,
  input  logic              colour_board_n,
  output logic [7:0]        io_rdata,
  output logic              rom_overlay,
  output logic              disp_off,
  output logic              line625,
  output logic              comp_video,
  output logic              cas_motor,
  output logic              beep_on,
  output logic              prn_strobe,
  output logic              cas_wdata
);
  import sysctl_pkg::*;

  logic               rst_s1;
  logic               rst_s2;
  logic [NUM_CTL-1:0] ctl_wen;
  logic               ctl_val;
  logic               rd_a;
  logic               rd_b;
  logic [NUM_CTL-1:1] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  sysctl_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTL(NUM_CTL), .VAL_BIT(VAL_BIT)
  ) u_decode (
    .clk(clk), .rst_n(rst_s2), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .ctl_wen(ctl_wen), .ctl_val(ctl_val),
    .rd_a(rd_a), .rd_b(rd_b)
  );

  sysctl_ffbank #(.NUM_CTL(NUM_CTL)) u_ffbank (
    .clk(clk), .rst_n(rst_s2), .ctl_wen(ctl_wen[NUM_CTL-1:1]),
    .ctl_val(ctl_val), .ctl_q(ctl_q)
  );

  sysctl_bankdefer u_bank (
    .clk(clk), .rst_n(rst_s2), .bank_wen(ctl_wen[CTL_BANK]),
    .bank_val(ctl_val), .m1_n(m1_n), .bank_sel(rom_overlay)
  );

  sysctl_status u_status (
    .clk(clk), .rst_n(rst_s2), .rd_a(rd_a), .rd_b(rd_b),
    .cas_rdata(cas_rdata), .prn_busy(prn_busy), .prn_ack(prn_ack),
    .model_id(model_id), .boot_mode(boot_mode), .reset_sw(reset_sw),
    .colour_board_n(colour_board_n), .rdata(io_rdata)
  );

  assign disp_off   = ctl_q[CTL_DISP_OFF];
  assign line625    = ctl_q[CTL_LINE625];
  assign comp_video = ctl_q[CTL_COMPVID];
  assign cas_motor  = ctl_q[CTL_CAS_MOTOR];
  assign beep_on    = ctl_q[CTL_BEEP];
  assign prn_strobe = ctl_q[CTL_PRN_STB];
  assign cas_wdata  = ctl_q[CTL_CAS_WR];

  // R2: a write to the beeper index reaches the beeper pin
  p_beep_map_r2: assert property (@(posedge clk) disable iff (!rst_s2)
    ctl_wen[CTL_BEEP] |=> (beep_on == $past(io_wdata[VAL_BIT])));
endmodule

// File: tb/tb_sysctl_bitlatch.sv
`timescale 1ns/1ps
module tb_sysctl_bitlatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic        m1_n = 1'b1;
  logic        cas_rdata = 1'b0, prn_busy = 1'b0, prn_ack = 1'b0, model_id = 1'b0;
  logic [1:0]  boot_mode = 2'b00;
  logic        reset_sw = 1'b0, colour_board_n = 1'b0;
  logic [7:0]  io_rdata;
  logic        rom_overlay, disp_off, line625, comp_video, cas_motor, beep_on, prn_strobe, cas_wdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  bit m_ctl [8];
  bit m_pend = 1'b1;
  bit m_bank = 1'b1;
  int m_rcnt = 0;

  always #2 clk = ~clk;

  sysctl_bitlatch dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .m1_n(m1_n), .cas_rdata(cas_rdata),
    .prn_busy(prn_busy), .prn_ack(prn_ack), .model_id(model_id),
    .boot_mode(boot_mode), .reset_sw(reset_sw), .colour_board_n(colour_board_n),
    .io_rdata(io_rdata), .rom_overlay(rom_overlay), .disp_off(disp_off),
    .line625(line625), .comp_video(comp_video), .cas_motor(cas_motor),
    .beep_on(beep_on), .prn_strobe(prn_strobe), .cas_wdata(cas_wdata)
  );

  function automatic logic [6:0] dut_ctl();
    return {cas_wdata, prn_strobe, beep_on, cas_motor, comp_video, line625, disp_off};
  endfunction

  function automatic logic [6:0] model_ctl();
    logic [6:0] v;
    for (int i = 1; i < 8; i++) v[i-1] = m_ctl[i];
    return v;
  endfunction

  function automatic logic [7:0] model_rdata();
    if (!io_rd) return 8'h00;
    if (io_addr[7:0] == 8'h1C)
      return {reset_sw, 2'b00, colour_board_n, 1'b0, model_id, 2'b00};
    if (io_addr[7:0] == 8'h1D)
      return {cas_rdata, 1'b1, 1'b0, prn_busy, prn_ack, model_id, boot_mode};
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, one update per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      if (!m1_n) m_bank = m_pend;
      if (io_wr && (io_addr[7:0] == 8'h1C || io_addr[7:0] == 8'h1D)) begin
        if (io_wdata[2:0] == 3'd0) m_pend = ~io_wdata[4];
        else                       m_ctl[io_wdata[2:0]] = io_wdata[4];
      end
    end
    if (m_rcnt < 2) begin
      for (int i = 0; i < 8; i++) m_ctl[i] = 1'b0;
      m_pend = 1'b1;
      m_bank = 1'b1;
    end
  end

  // cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(rom_overlay == m_bank, "R4 bank model", rom_overlay, m_bank);
      chk(dut_ctl() == model_ctl(), "R1 controls model", dut_ctl(), model_ctl());
      chk(io_rdata == model_rdata(), "R6/R7 rdata model", io_rdata, model_rdata());
    end
  end

  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input bit wr, input bit m1);
    @(negedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = wr; io_rd = 1'b0; m1_n = ~m1;
    @(posedge clk); #1;
    io_wr = 1'b0; m1_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); #1;
    io_addr = a; io_rd = 1'b1;
    #0.5;
    chk(io_rdata == exp, tag, io_rdata, exp);
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_ctl[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R8: state before the synchronizer releases
    chk(rom_overlay == 1'b1, "R8 bank during release", rom_overlay, 1);
    repeat (3) @(negedge clk);
    chk(rom_overlay == 1'b1, "R8 bank after reset", rom_overlay, 1);
    chk(dut_ctl() == 7'h00, "R8 controls after reset", dut_ctl(), 0);

    // R3: bank write is only pending while no fetch happens
    cyc(16'h001C, 8'h10, 1'b1, 1'b0);
    chk(rom_overlay == 1'b1, "R3 bank held on write", rom_overlay, 1);
    cyc(16'h0000, 8'h00, 1'b0, 1'b0);
    chk(rom_overlay == 1'b1, "R3 bank held w/o fetch", rom_overlay, 1);
    // R4: first fetch applies pending (inverse of 1 = 0)
    cyc(16'h0000, 8'h00, 1'b0, 1'b1);
    chk(rom_overlay == 1'b0, "R4 bank applied on fetch", rom_overlay, 0);
    // R4: write and fetch on the same edge
    cyc(16'h001D, 8'h00, 1'b1, 1'b1);
    chk(rom_overlay == 1'b0, "R4 same-edge keeps old pending", rom_overlay, 0);
    cyc(16'h0000, 8'h00, 1'b0, 1'b1);
    chk(rom_overlay == 1'b1, "R4 next fetch applies new", rom_overlay, 1);

    // R1: index 1 with bit3 set, then index 5 value 0 with bit3 set
    cyc(16'h001C, 8'h19, 1'b1, 1'b0);
    chk(dut_ctl() == 7'b0000001, "R1 single control load", dut_ctl(), 7'b0000001);
    cyc(16'h001C, 8'hED, 1'b1, 1'b0);
    chk(dut_ctl() == 7'b0000001, "R1 bit3/upper bits ignored", dut_ctl(), 7'b0000001);
    cyc(16'h001C, 8'h01, 1'b1, 1'b0);

    // R2: each index drives its own pin
    for (int i = 1; i < 8; i++) begin
      cyc(16'h001D, 8'h10 | 8'(i), 1'b1, 1'b0);
      chk(dut_ctl() == 7'(1 << (i - 1)), "R2 index to pin map", dut_ctl(), 1 << (i - 1));
      cyc(16'h001D, 8'(i), 1'b1, 1'b0);
    end
    chk(beep_on == 1'b0 && disp_off == 1'b0, "R2 cleared", dut_ctl(), 0);

    // R5: upper address ignored, other ports ignored
    cyc(16'hAB1D, 8'h13, 1'b1, 1'b0);
    chk(comp_video == 1'b1, "R5 upper byte ignored", comp_video, 1);
    cyc(16'h001E, 8'h15, 1'b1, 1'b0);
    chk(beep_on == 1'b0, "R5 other port ignored", beep_on, 0);
    cyc(16'h011B, 8'h10, 1'b1, 1'b1);
    chk(rom_overlay == 1'b1, "R5 other port no bank", rom_overlay, 1);
    cyc(16'hFF1C, 8'h17, 1'b1, 1'b0);
    chk(cas_wdata == 1'b1, "R5 write at 0xFF1C", cas_wdata, 1);

    // R6/R7/R9: status reads
    cas_rdata = 1'b1; prn_busy = 1'b0; prn_ack = 1'b1; model_id = 1'b1;
    boot_mode = 2'b10; reset_sw = 1'b1; colour_board_n = 1'b0;
    rd(16'h001D, 8'hCE, "R6 status B pattern 1");
    rd(16'h001C, 8'h84, "R7 status A pattern 1");
    cas_rdata = 1'b0; prn_busy = 1'b1; prn_ack = 1'b0; model_id = 1'b0;
    boot_mode = 2'b01; reset_sw = 1'b0; colour_board_n = 1'b1;
    rd(16'h5A1D, 8'h51, "R6 status B pattern 2");
    rd(16'h3C1C, 8'h10, "R7 status A pattern 2");
    rd(16'h001E, 8'h00, "R9 unmapped read");
    @(negedge clk); #1;
    io_addr = 16'h001D;
    #0.5;
    chk(io_rdata == 8'h00, "R9 no read strobe", io_rdata, 0);

    // randomized run against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); #1;
      case ($urandom_range(0, 3))
        0: io_addr = {8'($urandom), 8'h1C};
        1: io_addr = {8'($urandom), 8'h1D};
        2: io_addr = {8'($urandom), 8'h1C + 8'($urandom_range(0, 3))};
        default: io_addr = 16'($urandom);
      endcase
      io_wdata = 8'($urandom);
      io_wr = ($urandom_range(0, 2) != 0);
      io_rd = 1'($urandom);
      m1_n = 1'($urandom);
      {cas_rdata, prn_busy, prn_ack, model_id, reset_sw, colour_board_n} = 6'($urandom);
      boot_mode = 2'($urandom);
    end
    @(negedge clk); #1;
    io_wr = 1'b0; io_rd = 1'b0; m1_n = 1'b1;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule